// File: doc/BRIEF.md
# Flash Command Register Decoder

This block sits between a host write port and the embedded program/erase sequencer of a byte-wide flash array. Each host write arrives as a one-cycle strobe carrying an address and a data byte. The block decodes these bytes as commands and holds the device mode. It issues a single-cycle start pulse when an operation that changes memory has been set up and then confirmed. It also captures the operands that the sequencer needs: the address and data to program, the address to erase-verify, and a mask of the blocks selected for erase.

Any operation that alters memory takes two writes: a set-up byte, then a matching confirm byte. A wrong confirm byte drops back to array read. While an operation runs, the block ignores every write except a pair of consecutive FFH bytes, which aborts it. After a failure, only that same pair brings the block back. When the high-voltage flag goes low, the block falls back to array read. Block erase collects block addresses: the confirm write loads the first one, and each further write loads another, as long as no more than `LOAD_WIN` idle cycles pass between them. When that window runs out, the erase starts.

States: `ST_READ`, `ST_IDENT`, `ST_VERIFY` (command-accepting states), `ST_SU_PROG`, `ST_SU_ACHIP`, `ST_SU_20`, `ST_SU_60` (awaiting confirm), `ST_LOAD` (collecting blocks), `ST_BUSY` (operation running), `ST_FAIL` (operation failed). The transitions are:
- decode: from a command-accepting state, the written byte selects the next state.
- confirm: from a set-up state, a matching byte leads to `ST_BUSY` or `ST_LOAD`.
- mismatch: from a set-up state, any other byte returns to `ST_READ`.
- window-expiry: `ST_LOAD` moves to `ST_BUSY`.
- done: `ST_BUSY` returns to `ST_READ`.
- fail: `ST_BUSY` moves to `ST_FAIL`.
- abort-pair: `ST_BUSY` or `ST_FAIL` returns to `ST_READ`.
- supply-loss: any state returns to `ST_READ`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the mode output is 0 and every start pulse, the abort pulse, id_data, blk_mask and prog_addr are zero. The mode codes are 0 read, 1 identifier, 2 set-up, 3 block load, 4 busy, 5 verify and 6 fail.
- R2: While hv_ok is low, writes have no effect. The cycle after hv_ok is seen low, mode reads 0. If mode was 4 or 3 at that time, abort_pulse is high for that one cycle.
- R3: Writing 90H selects mode 1. In mode 1, id_data is C2H when rd_sel is 0 and 1AH when rd_sel is 1. In every other mode, id_data is 0.
- R4: After a 40H write, the next write of any byte (FFH included) stores its address in prog_addr and its data in prog_data, raises start_auto_prog for one cycle, and enters mode 4.
- R5: A 30H write followed by a second 30H raises start_auto_chip for one cycle and enters mode 4.
- R6: A 20H write followed by a second 20H raises start_chip_erase and enters mode 4. A 20H write followed by D0H enters mode 3 for an automatic block erase.
- R7: A 60H write followed by a second 60H enters mode 3 for a plain block erase. When the window expires, start_block_erase pulses.
- R8: In mode 3, the confirm write and every later write set the blk_mask bit selected by wr_addr bits 16..14. A write restarts the LOAD_WIN window and takes priority over its expiry. LOAD_WIN cycles after the last write, the start pulse fires, mode becomes 4, and blk_mask holds its value.
- R9: Writing A0H enters mode 5 and copies that write's address into verify_addr.
- R10: In a set-up state other than the program set-up, a confirm byte that does not match returns to mode 0 and starts nothing.
- R11: In mode 4, writes leave mode, prog_addr and prog_data unchanged. The exception is two FFH writes with no other write between them: that pair returns to mode 0 with a one-cycle abort_pulse.
- R12: In mode 4, alg_fail leads to mode 6 and alg_done leads to mode 0. In mode 6, only the FFH pair leaves, to mode 0.
- R13: From mode 0, 1 or 5, writing 00H or any byte that is not a command gives mode 0.
- R14: At most one start pulse is high in any cycle, and a start pulse only follows a cycle in which hv_ok was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_ok | input | 1 | Programming supply present |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | AW | Address carried by the write |
| wr_data | input | 8 | Data byte carried by the write |
| alg_done | input | 1 | Sequencer finished successfully |
| alg_fail | input | 1 | Sequencer reports a failure |
| rd_sel | input | 1 | Address bit 0 of an identifier read |
| mode | output | 3 | Current mode code |
| id_data | output | 8 | Identifier byte in mode 1, else 0 |
| start_auto_prog | output | 1 | Start automatic byte program |
| start_auto_chip | output | 1 | Start automatic chip erase |
| start_auto_block | output | 1 | Start automatic block erase |
| start_chip_erase | output | 1 | Start plain chip erase |
| start_block_erase | output | 1 | Start plain block erase |
| abort_pulse | output | 1 | Running operation aborted |
| prog_addr | output | AW | Captured program address |
| prog_data | output | 8 | Captured program data |
| verify_addr | output | AW | Captured erase-verify address |
| blk_mask | output | NBLK | Blocks selected for erase |

## Verification
The assertions assume wr_stb is a single-cycle pulse and that alg_done and alg_fail only pulse while an operation is running. They also assume hv_ok is synchronous to clk. The bench drives every input on the falling edge and raises each strobe and completion flag for exactly one cycle. It pulses alg_done or alg_fail only after it has seen mode 4. It only changes hv_ok on a falling edge, so each property sees clean, single-cycle input events.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_STARTS = 5;

    // start vector bit positions
    localparam int SI_APROG = 0;
    localparam int SI_ACHIP = 1;
    localparam int SI_ABLK  = 2;
    localparam int SI_CHIP  = 3;
    localparam int SI_BLK   = 4;

    // command byte values
    localparam logic [BYTE_W-1:0] OP_READ    = 8'h00;
    localparam logic [BYTE_W-1:0] OP_IDENT   = 8'h90;
    localparam logic [BYTE_W-1:0] OP_PROG_SU = 8'h40;
    localparam logic [BYTE_W-1:0] OP_ACHIP   = 8'h30;
    localparam logic [BYTE_W-1:0] OP_SU20    = 8'h20;
    localparam logic [BYTE_W-1:0] OP_ABLK_GO = 8'hD0;
    localparam logic [BYTE_W-1:0] OP_BLK     = 8'h60;
    localparam logic [BYTE_W-1:0] OP_VERIFY  = 8'hA0;
    localparam logic [BYTE_W-1:0] OP_ABORT   = 8'hFF;

    typedef enum logic [2:0] {
        MODE_READ   = 3'd0,
        MODE_IDENT  = 3'd1,
        MODE_SETUP  = 3'd2,
        MODE_LOAD   = 3'd3,
        MODE_BUSY   = 3'd4,
        MODE_VERIFY = 3'd5,
        MODE_FAIL   = 3'd6
    } mode_t;

    typedef enum logic [3:0] {
        ST_READ,
        ST_IDENT,
        ST_VERIFY,
        ST_SU_PROG,
        ST_SU_ACHIP,
        ST_SU_20,
        ST_SU_60,
        ST_LOAD,
        ST_BUSY,
        ST_FAIL
    } state_t;

endpackage

// File: rtl/fcd_hold_reg.sv
module fcd_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/fcd_id_table.sv
module fcd_id_table #(
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'h1A
) (
    input  logic       en,
    input  logic       sel,
    output logic [7:0] q
);
    always_comb begin
        if (!en)
            q = '0;
        else if (sel)
            q = DEV_CODE;
        else
            q = MFR_CODE;
    end
endmodule

// File: rtl/fcd_blk_loader.sv
module fcd_blk_loader #(
    parameter int NBLK     = 8,
    parameter int BW       = 3,
    parameter int LOAD_WIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            clr,
    input  logic            add,
    input  logic [BW-1:0]   idx,
    output logic [NBLK-1:0] mask,
    output logic            expired
);
    localparam int CW = (LOAD_WIN > 2) ? $clog2(LOAD_WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOAD_WIN - 1);

    logic [NBLK-1:0] hit;
    logic [CW-1:0]   cnt;

    assign hit     = {{(NBLK-1){1'b0}}, 1'b1} << idx;
    assign expired = arm && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            cnt  <= '0;
        end else begin
            if (clr)
                mask <= add ? hit : '0;
            else if (add)
                mask <= mask | hit;

            if (add || !arm)
                cnt <= '0;
            else if (cnt != LAST)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
    import fcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hv_ok,
    input  logic                  wr_stb,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  alg_done,
    input  logic                  alg_fail,
    input  logic                  load_expired,
    output mode_t                 mode,
    output logic [NUM_STARTS-1:0] start,
    output logic                  abort_pulse,
    output logic                  prog_latch,
    output logic                  vfy_latch,
    output logic                  blk_clr,
    output logic                  blk_add,
    output logic                  blk_arm
);
    state_t                state, state_nxt;
    logic                  armed, armed_nxt;
    logic                  load_auto, load_auto_nxt;
    logic [NUM_STARTS-1:0] start_nxt;
    logic                  abort_nxt;
    logic                  is_ff;

    assign is_ff   = (wr_data == OP_ABORT);
    assign blk_arm = hv_ok && (state == ST_LOAD);

    // next-state and strobe decode
    always_comb begin
        state_nxt     = state;
        armed_nxt     = armed;
        load_auto_nxt = load_auto;
        start_nxt     = '0;
        abort_nxt     = 1'b0;
        prog_latch    = 1'b0;
        vfy_latch     = 1'b0;
        blk_clr       = 1'b0;
        blk_add       = 1'b0;

        if (!hv_ok) begin
            state_nxt = ST_READ;
            armed_nxt = 1'b0;
            abort_nxt = (state == ST_BUSY) || (state == ST_LOAD);
        end else begin
            unique case (state)
                ST_READ, ST_IDENT, ST_VERIFY: begin
                    if (wr_stb) begin
                        case (wr_data)
                            OP_IDENT:   state_nxt = ST_IDENT;
                            OP_PROG_SU: state_nxt = ST_SU_PROG;
                            OP_ACHIP:   state_nxt = ST_SU_ACHIP;
                            OP_SU20:    state_nxt = ST_SU_20;
                            OP_BLK:     state_nxt = ST_SU_60;
                            OP_VERIFY: begin
                                state_nxt = ST_VERIFY;
                                vfy_latch = 1'b1;
                            end
                            default:    state_nxt = ST_READ;
                        endcase
                    end
                end
                ST_SU_PROG: begin
                    if (wr_stb) begin
                        state_nxt           = ST_BUSY;
                        prog_latch          = 1'b1;
                        start_nxt[SI_APROG] = 1'b1;
                    end
                end
                ST_SU_ACHIP: begin
                    if (wr_stb) begin
                        if (wr_data == OP_ACHIP) begin
                            state_nxt           = ST_BUSY;
                            start_nxt[SI_ACHIP] = 1'b1;
                        end else begin
                            state_nxt = ST_READ;
                        end
                    end
                end
                ST_SU_20: begin
                    if (wr_stb) begin
                        if (wr_data == OP_SU20) begin
                            state_nxt          = ST_BUSY;
                            start_nxt[SI_CHIP] = 1'b1;
                        end else if (wr_data == OP_ABLK_GO) begin
                            state_nxt     = ST_LOAD;
                            blk_clr       = 1'b1;
                            blk_add       = 1'b1;
                            load_auto_nxt = 1'b1;
                        end else begin
                            state_nxt = ST_READ;
                        end
                    end
                end
                ST_SU_60: begin
                    if (wr_stb) begin
                        if (wr_data == OP_BLK) begin
                            state_nxt     = ST_LOAD;
                            blk_clr       = 1'b1;
                            blk_add       = 1'b1;
                            load_auto_nxt = 1'b0;
                        end else begin
                            state_nxt = ST_READ;
                        end
                    end
                end
                ST_LOAD: begin
                    if (wr_stb) begin
                        blk_add = 1'b1;
                    end else if (load_expired) begin
                        state_nxt = ST_BUSY;
                        start_nxt[load_auto ? SI_ABLK : SI_BLK] = 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (alg_fail) begin
                        state_nxt = ST_FAIL;
                        armed_nxt = 1'b0;
                    end else if (alg_done) begin
                        state_nxt = ST_READ;
                        armed_nxt = 1'b0;
                    end else if (wr_stb) begin
                        if (is_ff && armed) begin
                            state_nxt = ST_READ;
                            armed_nxt = 1'b0;
                            abort_nxt = 1'b1;
                        end else begin
                            armed_nxt = is_ff;
                        end
                    end
                end
                ST_FAIL: begin
                    if (wr_stb) begin
                        if (is_ff && armed) begin
                            state_nxt = ST_READ;
                            armed_nxt = 1'b0;
                            abort_nxt = 1'b1;
                        end else begin
                            armed_nxt = is_ff;
                        end
                    end
                end
                default: state_nxt = ST_READ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READ;
            armed     <= 1'b0;
            load_auto <= 1'b0;
        end else begin
            state     <= state_nxt;
            armed     <= armed_nxt;
            load_auto <= load_auto_nxt;
        end
    end

    // registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start       <= '0;
            abort_pulse <= 1'b0;
        end else begin
            start       <= start_nxt;
            abort_pulse <= abort_nxt;
        end
    end

    // mode indication
    always_comb begin
        unique case (state)
            ST_READ:                                    mode = MODE_READ;
            ST_IDENT:                                   mode = MODE_IDENT;
            ST_VERIFY:                                  mode = MODE_VERIFY;
            ST_SU_PROG, ST_SU_ACHIP, ST_SU_20, ST_SU_60: mode = MODE_SETUP;
            ST_LOAD:                                    mode = MODE_LOAD;
            ST_BUSY:                                    mode = MODE_BUSY;
            ST_FAIL:                                    mode = MODE_FAIL;
            default:                                    mode = MODE_READ;
        endcase
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         AW       = 17,
    parameter int         NBLK     = 8,
    parameter int         LOAD_WIN = 16,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'h1A
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hv_ok,
    input  logic            wr_stb,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic            alg_done,
    input  logic            alg_fail,
    input  logic            rd_sel,
    output logic [2:0]      mode,
    output logic [7:0]      id_data,
    output logic            start_auto_prog,
    output logic            start_auto_chip,
    output logic            start_auto_block,
    output logic            start_chip_erase,
    output logic            start_block_erase,
    output logic            abort_pulse,
    output logic [AW-1:0]   prog_addr,
    output logic [7:0]      prog_data,
    output logic [AW-1:0]   verify_addr,
    output logic [NBLK-1:0] blk_mask
);
    localparam int BW = $clog2(NBLK);

    mode_t                 fsm_mode;
    logic [NUM_STARTS-1:0] start_vec;
    logic                  prog_latch, vfy_latch;
    logic                  blk_clr, blk_add, blk_arm, load_expired;

    fcd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hv_ok        (hv_ok),
        .wr_stb       (wr_stb),
        .wr_data      (wr_data),
        .alg_done     (alg_done),
        .alg_fail     (alg_fail),
        .load_expired (load_expired),
        .mode         (fsm_mode),
        .start        (start_vec),
        .abort_pulse  (abort_pulse),
        .prog_latch   (prog_latch),
        .vfy_latch    (vfy_latch),
        .blk_clr      (blk_clr),
        .blk_add      (blk_add),
        .blk_arm      (blk_arm)
    );

    fcd_blk_loader #(.NBLK(NBLK), .BW(BW), .LOAD_WIN(LOAD_WIN)) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (blk_arm),
        .clr     (blk_clr),
        .add     (blk_add),
        .idx     (wr_addr[AW-1 -: BW]),
        .mask    (blk_mask),
        .expired (load_expired)
    );

    fcd_hold_reg #(.W(AW)) u_prog_addr (
        .clk(clk), .rst_n(rst_n), .en(prog_latch), .d(wr_addr), .q(prog_addr)
    );
    fcd_hold_reg #(.W(BYTE_W)) u_prog_data (
        .clk(clk), .rst_n(rst_n), .en(prog_latch), .d(wr_data), .q(prog_data)
    );
    fcd_hold_reg #(.W(AW)) u_vfy_addr (
        .clk(clk), .rst_n(rst_n), .en(vfy_latch), .d(wr_addr), .q(verify_addr)
    );

    fcd_id_table #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .en  (fsm_mode == MODE_IDENT),
        .sel (rd_sel),
        .q   (id_data)
    );

    assign mode              = fsm_mode;
    assign start_auto_prog   = start_vec[SI_APROG];
    assign start_auto_chip   = start_vec[SI_ACHIP];
    assign start_auto_block  = start_vec[SI_ABLK];
    assign start_chip_erase  = start_vec[SI_CHIP];
    assign start_block_erase = start_vec[SI_BLK];
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
#(
    parameter int AW = 17
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hv_ok,
    input logic                  alg_done,
    input logic                  alg_fail,
    input logic [2:0]            mode,
    input logic [7:0]            id_data,
    input logic [NUM_STARTS-1:0] starts,
    input logic                  abort_pulse,
    input logic [AW-1:0]         prog_addr,
    input logic [7:0]            prog_data
);
    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(starts)); // R14

    AST_START_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
        (|starts) |-> $past(hv_ok)); // R14

    AST_START_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|starts) |-> (mode == MODE_BUSY)); // R4

    AST_HV_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_ok |=> (mode == MODE_READ)); // R2

    AST_DONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_ok && mode == MODE_BUSY && alg_done && !alg_fail) |=> (mode == MODE_READ)); // R12

    AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_IDENT) |-> (id_data == 8'h00)); // R3

    AST_ABORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (mode == MODE_READ)); // R11

    AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BUSY && $past(mode) == MODE_BUSY) |->
            ($stable(prog_addr) && $stable(prog_data))); // R11
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hv_ok       (hv_ok),
    .alg_done    (alg_done),
    .alg_fail    (alg_fail),
    .mode        (mode),
    .id_data     (id_data),
    .starts      (start_vec),
    .abort_pulse (abort_pulse),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW  = 17;
    localparam int NB  = 8;
    localparam int WIN = 16;

    localparam logic [2:0] M_RD = 3'd0, M_ID = 3'd1, M_SU = 3'd2, M_LD = 3'd3,
                           M_BZ = 3'd4, M_VF = 3'd5, M_FL = 3'd6;

    typedef struct packed {
        logic [1:0]    kind;   // 0 write, 1 done pulse, 2 fail pulse
        logic [7:0]    data;
        logic [AW-1:0] addr;
        logic [2:0]    emode;
        logic [4:0]    est;    // {blk, chip, ablk, achip, aprog}
        logic          eab;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h00, 17'h00000, M_RD, 5'b00000, 1'b0, 4'd13}, // R13
        '{2'd0, 8'h90, 17'h00000, M_ID, 5'b00000, 1'b0, 4'd3 }, // R3
        '{2'd0, 8'h40, 17'h00000, M_SU, 5'b00000, 1'b0, 4'd4 }, // R4
        '{2'd0, 8'h55, 17'h01234, M_BZ, 5'b00001, 1'b0, 4'd4 }, // R4
        '{2'd1, 8'h00, 17'h00000, M_RD, 5'b00000, 1'b0, 4'd12}, // R12
        '{2'd0, 8'h30, 17'h00000, M_SU, 5'b00000, 1'b0, 4'd5 }, // R5
        '{2'd0, 8'h30, 17'h00000, M_BZ, 5'b00010, 1'b0, 4'd5 }, // R5
        '{2'd0, 8'h12, 17'h00000, M_BZ, 5'b00000, 1'b0, 4'd11}, // R11
        '{2'd0, 8'hFF, 17'h00000, M_BZ, 5'b00000, 1'b0, 4'd11}, // R11
        '{2'd0, 8'hFF, 17'h00000, M_RD, 5'b00000, 1'b1, 4'd11}, // R11
        '{2'd0, 8'h30, 17'h00000, M_SU, 5'b00000, 1'b0, 4'd10}, // R10
        '{2'd0, 8'h55, 17'h00000, M_RD, 5'b00000, 1'b0, 4'd10}, // R10
        '{2'd0, 8'h20, 17'h00000, M_SU, 5'b00000, 1'b0, 4'd6 }, // R6
        '{2'd0, 8'h20, 17'h00000, M_BZ, 5'b01000, 1'b0, 4'd6 }, // R6
        '{2'd2, 8'h00, 17'h00000, M_FL, 5'b00000, 1'b0, 4'd12}, // R12
        '{2'd0, 8'h00, 17'h00000, M_FL, 5'b00000, 1'b0, 4'd12}, // R12
        '{2'd0, 8'hFF, 17'h00000, M_FL, 5'b00000, 1'b0, 4'd12}, // R12
        '{2'd0, 8'hFF, 17'h00000, M_RD, 5'b00000, 1'b1, 4'd12}, // R12
        '{2'd0, 8'h60, 17'h00000, M_SU, 5'b00000, 1'b0, 4'd7 }, // R7
        '{2'd0, 8'h20, 17'h00000, M_RD, 5'b00000, 1'b0, 4'd10}, // R10
        '{2'd0, 8'hA0, 17'h00ABC, M_VF, 5'b00000, 1'b0, 4'd9 }, // R9
        '{2'd0, 8'h77, 17'h00000, M_RD, 5'b00000, 1'b0, 4'd13}, // R13
        '{2'd0, 8'hFF, 17'h00000, M_RD, 5'b00000, 1'b0, 4'd13}, // R13
        '{2'd0, 8'h40, 17'h00000, M_SU, 5'b00000, 1'b0, 4'd4 }, // R4
        '{2'd0, 8'hFF, 17'h00042, M_BZ, 5'b00001, 1'b0, 4'd4 }, // R4 data FFH programs
        '{2'd0, 8'hFF, 17'h00000, M_BZ, 5'b00000, 1'b0, 4'd11}, // R11
        '{2'd0, 8'hFF, 17'h00000, M_RD, 5'b00000, 1'b1, 4'd11}  // R11
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hv_ok = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          alg_done = 1'b0;
    logic          alg_fail = 1'b0;
    logic          rd_sel = 1'b0;
    logic [2:0]    mode;
    logic [7:0]    id_data;
    logic          start_auto_prog, start_auto_chip, start_auto_block;
    logic          start_chip_erase, start_block_erase, abort_pulse;
    logic [AW-1:0] prog_addr, verify_addr;
    logic [7:0]    prog_data;
    logic [NB-1:0] blk_mask;
    logic [4:0]    starts;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    assign starts = {start_block_erase, start_chip_erase, start_auto_block,
                     start_auto_chip, start_auto_prog};

    flash_cmd_decoder #(.AW(AW), .NBLK(NB), .LOAD_WIN(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .alg_done(alg_done),
        .alg_fail(alg_fail), .rd_sel(rd_sel), .mode(mode), .id_data(id_data),
        .start_auto_prog(start_auto_prog), .start_auto_chip(start_auto_chip),
        .start_auto_block(start_auto_block), .start_chip_erase(start_chip_erase),
        .start_block_erase(start_block_erase), .abort_pulse(abort_pulse),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .verify_addr(verify_addr), .blk_mask(blk_mask)
    );

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); alg_done = 1'b1;
        @(negedge clk); alg_done = 1'b0;
    endtask

    task automatic pulse_fail();
        @(negedge clk); alg_fail = 1'b1;
        @(negedge clk); alg_fail = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(1, {29'd0, mode}, {29'd0, M_RD});
        chk(1, {27'd0, starts}, 32'd0);
        chk(1, {31'd0, abort_pulse}, 32'd0);
        chk(1, {24'd0, id_data}, 32'd0);
        chk(1, {24'd0, blk_mask}, 32'd0);
        chk(1, {15'd0, prog_addr}, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            case (v.kind)
                2'd0:    host_wr(v.addr, v.data);
                2'd1:    pulse_done();
                default: pulse_fail();
            endcase
            chk(int'(v.req), {23'd0, mode, starts, abort_pulse},
                {23'd0, v.emode, v.est, v.eab});
        end
        chk(4, {15'd0, prog_addr}, 32'h42);   // R4
        chk(4, {24'd0, prog_data}, 32'hFF);   // R4
        chk(9, {15'd0, verify_addr}, 32'hABC); // R9

        // R3 identifier bytes
        host_wr('0, 8'h90);
        rd_sel = 1'b0; #1;
        chk(3, {24'd0, id_data}, 32'hC2);
        rd_sel = 1'b1; #1;
        chk(3, {24'd0, id_data}, 32'h1A);
        host_wr('0, 8'h00);
        chk(3, {24'd0, id_data}, 32'h00);

        // R11 busy writes ignored; non-FF between FF bytes breaks the pair
        host_wr('0, 8'h40);
        host_wr(17'h00111, 8'hAA);
        host_wr(17'h1FFFF, 8'hFF);
        host_wr(17'h1FFFF, 8'h40);
        host_wr(17'h1FFFF, 8'hFF);
        chk(11, {29'd0, mode}, {29'd0, M_BZ});
        chk(11, {15'd0, prog_addr}, 32'h111);
        chk(11, {24'd0, prog_data}, 32'hAA);
        pulse_done();
        chk(12, {29'd0, mode}, {29'd0, M_RD});

        // R6 R8 automatic block erase with a second block and window restart
        host_wr('0, 8'h20);
        host_wr(17'(5) << 14, 8'hD0);
        chk(6, {29'd0, mode}, {29'd0, M_LD});
        repeat (WIN - 2) @(negedge clk);
        chk(8, {27'd0, starts}, 32'd0);
        host_wr(17'(2) << 14, 8'h33);   // captured on the expiry edge
        chk(8, {29'd0, mode}, {29'd0, M_LD});
        repeat (WIN - 1) @(negedge clk);
        chk(8, {24'd0, mode, starts}, {24'd0, M_LD, 5'b00000});
        @(negedge clk);
        chk(8, {24'd0, mode, starts}, {24'd0, M_BZ, 5'b00100});
        chk(8, {24'd0, blk_mask}, 32'h24);
        pulse_done();

        // R7 plain block erase
        host_wr('0, 8'h60);
        host_wr(17'(7) << 14, 8'h60);
        repeat (WIN) @(negedge clk);
        chk(7, {24'd0, mode, starts}, {24'd0, M_BZ, 5'b10000});
        chk(7, {24'd0, blk_mask}, 32'h80);
        pulse_done();

        // R2 supply loss while busy and in set-up
        host_wr('0, 8'h30);
        host_wr('0, 8'h30);
        hv_ok = 1'b0;
        @(negedge clk);
        chk(2, {28'd0, mode, abort_pulse}, {28'd0, M_RD, 1'b1});
        @(negedge clk);
        chk(2, {31'd0, abort_pulse}, 32'd0);
        host_wr('0, 8'h90);
        chk(2, {21'd0, mode, id_data}, {21'd0, M_RD, 8'h00});
        @(negedge clk); hv_ok = 1'b1;
        host_wr('0, 8'h40);
        chk(2, {29'd0, mode}, {29'd0, M_SU});
        hv_ok = 1'b0;
        @(negedge clk);
        chk(2, {28'd0, mode, abort_pulse}, {28'd0, M_RD, 1'b0});
        hv_ok = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule